// File: doc/BRIEF.md
# Bit-Serial CRC Generator and Checker

This block divides a serial bit stream by a fixed generator polynomial in modulo-2 arithmetic. It uses a shift register with XOR feedback taps. Its width and tap pattern are parameters. The default build uses the degree-16 generator x^16 + x^15 + x^2 + 1 (tap constant `16'h8005`, the x^16 term implied). A degree-5 build uses x^5 + x^2 + 1 (tap constant `5'h05`). Bits enter most-significant first. The register starts at zero for every message. No preset and no final inversion are applied.

In generate mode the block accepts message bits until a bit marked last. It then sends the n-bit remainder, MSB first, on a serial output stream. The sender appends these bits to the message to form the codeword. In check mode the block accepts a whole codeword, including its appended remainder. In the cycle after the last bit it raises a one-cycle verdict saying whether the remainder is zero. A zero remainder means that no error was detected.

Both streams use valid/ready handshakes. A bit moves on a clock edge where valid and ready are both high. The source must hold the bit, the last flag and valid until the bit is accepted. The input ready is low while the remainder is being sent and during the verdict cycle. When the sink holds output ready low, the output bit and the register stay frozen. A synchronous clear abandons any message in progress.

Top module: `crc_serial`

## Requirements
- R1: After reset or a one-cycle clear, the block is ready for a new message. The input ready is high, the remainder is zero, and the output valid, output last and verdict strobe are low. A clear issued in the middle of a message or a flush discards that message.
- R2: In generate mode, the remainder output after the last accepted bit equals the message times x^n, modulo the generator. Bits enter MSB first into a register that starts at zero.
- R3: For the degree-5 generator (tap constant 5'h05), the message 10100101 yields remainder 01110. The codeword 1010010101110 checks as error-free.
- R4: After the last bit in generate mode, output valid stays high for exactly n accepted output beats. These beats carry the remainder MSB first, and output last is high only on the n-th beat. Input ready is low for the whole flush, so the data input and input valid are ignored.
- R5: While output valid is high and output ready is low, the output bit, the remainder and the beat position hold.
- R6: After the n-th output beat, the register is zero and input ready is high again. The next message gives the same result as it would after a reset.
- R7: In check mode, the verdict strobe is high for exactly one cycle, the cycle after the last codeword bit is accepted. In that cycle the zero flag is high if the codeword is divisible by the generator. Input ready is low in that cycle.
- R8: A codeword with one or two flipped bits gives a verdict with the zero flag low.
- R9: The mode input is sampled with the first bit of each message. Changes to it later in the same message have no effect.
- R10: A cycle with input valid low adds no bit to the division, and the remainder holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous restart, zeroes the register |
| mode_chk_i | input | 1 | 0 = generate, 1 = check; sampled on the first bit |
| in_valid_i | input | 1 | Input bit valid |
| in_ready_o | output | 1 | Block can accept a bit |
| in_bit_i | input | 1 | Serial data bit, MSB first |
| in_last_i | input | 1 | Marks the final bit of the message or codeword |
| out_valid_o | output | 1 | Remainder bit valid (generate flush) |
| out_ready_i | input | 1 | Sink accepts the remainder bit |
| out_bit_o | output | 1 | Remainder bit, MSB first |
| out_last_o | output | 1 | Marks the final remainder bit |
| chk_done_o | output | 1 | One-cycle verdict strobe in check mode |
| chk_zero_o | output | 1 | Remainder is zero (valid with the strobe) |
| rem_o | output | W | Current register contents |

## Verification
A wrong tap or a wrong feedback bit shows up on `rem_o` on the clock edge after the first message bit that triggers feedback. It then corrupts every later remainder bit and the check verdict of every codeword. A flush counter that is off by one changes the number of output beats, or where the last beat falls. This can be seen within n cycles of the last input bit. The register is also left non-zero, which spoils the next message. Faults in the handshake or the mode latch show at the next gap, stall or mode change: a bit is added or lost, the output bit moves while stalled, or a flush appears where a verdict was expected.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

  typedef enum logic [1:0] {
    ST_TAKE    = 2'd0,
    ST_FLUSH   = 2'd1,
    ST_VERDICT = 2'd2
  } crc_state_e;

  typedef enum logic {
    MODE_GEN = 1'b0,
    MODE_CHK = 1'b1
  } crc_mode_e;

endpackage

// File: rtl/crc_lfsr.sv
module crc_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = 16'h8005
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         fb_en,
  input  logic         din,
  output logic [W-1:0] rem
);

  logic [W-1:0] r_q;
  logic [W-1:0] r_nxt;
  logic         fb;

  // feedback only while dividing; during flush the register shifts with zero fill
  assign fb = fb_en & (din ^ r_q[W-1]);

  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign r_nxt[0] = fb & POLY[0];
    end else begin : g_up
      assign r_nxt[i] = r_q[i-1] ^ (fb & POLY[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_q <= '0;
    end else if (clr) begin
      r_q <= '0;
    end else if (shift_en) begin
      r_q <= r_nxt;
    end
  end

  assign rem = r_q;

endmodule

// File: rtl/crc_seq.sv
module crc_seq
  import crc_serial_pkg::*;
#(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic mode_chk,
  input  logic in_valid,
  input  logic in_last,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic out_last,
  output logic chk_done,
  output logic reg_clr,
  output logic shift_en,
  output logic fb_en
);

  localparam int             CW       = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0]  LAST_IDX = CW'(W - 1);

  crc_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic          first_q;
  crc_mode_e     mode_q;
  crc_mode_e     mode_eff;
  logic          take;
  logic          beat;

  assign mode_eff = first_q ? crc_mode_e'(mode_chk) : mode_q;
  assign take     = (st_q == ST_TAKE) && in_valid;
  assign beat     = (st_q == ST_FLUSH) && out_ready;

  assign in_ready  = (st_q == ST_TAKE);
  assign out_valid = (st_q == ST_FLUSH);
  assign out_last  = (st_q == ST_FLUSH) && (cnt_q == LAST_IDX);
  assign chk_done  = (st_q == ST_VERDICT);
  assign shift_en  = take | beat;
  assign fb_en     = (st_q == ST_TAKE);
  assign reg_clr   = clear | (st_q == ST_VERDICT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_TAKE;
      cnt_q   <= '0;
      first_q <= 1'b1;
      mode_q  <= MODE_GEN;
    end else if (clear) begin
      st_q    <= ST_TAKE;
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else begin
      case (st_q)
        ST_TAKE: begin
          if (take) begin
            if (first_q) mode_q <= crc_mode_e'(mode_chk);
            if (in_last) begin
              first_q <= 1'b1;
              cnt_q   <= '0;
              st_q    <= (mode_eff == MODE_CHK) ? ST_VERDICT : ST_FLUSH;
            end else begin
              first_q <= 1'b0;
            end
          end
        end
        ST_FLUSH: begin
          if (beat) begin
            if (cnt_q == LAST_IDX) begin
              st_q  <= ST_TAKE;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_VERDICT: st_q <= ST_TAKE;
        default:    st_q <= ST_TAKE;
      endcase
    end
  end

endmodule

// File: rtl/crc_serial.sv
module crc_serial #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = 16'h8005
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         mode_chk_i,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic         in_bit_i,
  input  logic         in_last_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic         out_bit_o,
  output logic         out_last_o,
  output logic         chk_done_o,
  output logic         chk_zero_o,
  output logic [W-1:0] rem_o
);

  logic reg_clr;
  logic shift_en;
  logic fb_en;
  logic [W-1:0] rem;

  crc_seq #(.W(W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear_i),
    .mode_chk  (mode_chk_i),
    .in_valid  (in_valid_i),
    .in_last   (in_last_i),
    .out_ready (out_ready_i),
    .in_ready  (in_ready_o),
    .out_valid (out_valid_o),
    .out_last  (out_last_o),
    .chk_done  (chk_done_o),
    .reg_clr   (reg_clr),
    .shift_en  (shift_en),
    .fb_en     (fb_en)
  );

  crc_lfsr #(.W(W), .POLY(POLY)) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (reg_clr),
    .shift_en (shift_en),
    .fb_en    (fb_en),
    .din      (in_bit_i),
    .rem      (rem)
  );

  assign rem_o      = rem;
  assign out_bit_o  = rem[W-1];
  assign chk_zero_o = chk_done_o && (rem == '0);

endmodule

// File: rtl/crc_serial_chk.sv
module crc_serial_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clear_i,
  input logic         in_valid_i,
  input logic         in_ready_o,
  input logic         out_valid_o,
  input logic         out_ready_i,
  input logic         out_bit_o,
  input logic         out_last_o,
  input logic         chk_done_o,
  input logic         chk_zero_o,
  input logic [W-1:0] rem_o
);

  AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (rem_o == '0) && in_ready_o && !out_valid_o && !chk_done_o) // R1
    else $error("clear did not restart");

  AST_FLUSH_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> !in_ready_o) // R4
    else $error("input ready during flush");

  AST_LAST_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    out_last_o |-> out_valid_o) // R4
    else $error("last outside flush");

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || clear_i)
    (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(out_bit_o) && $stable(rem_o) && $stable(out_last_o)) // R5
    else $error("stalled output moved");

  AST_VERDICT_PULSE: assert property (@(posedge clk) disable iff (!rst_n || clear_i)
    chk_done_o |=> !chk_done_o && in_ready_o) // R7
    else $error("verdict not a single pulse");

  AST_ZERO_WITH_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    chk_zero_o |-> chk_done_o && !in_ready_o) // R7
    else $error("zero flag outside verdict");

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || clear_i)
    (in_ready_o && !in_valid_i) |=> $stable(rem_o)) // R10
    else $error("register moved without a bit");

endmodule

bind crc_serial crc_serial_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clear_i     (clear_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_bit_o   (out_bit_o),
  .out_last_o  (out_last_o),
  .chk_done_o  (chk_done_o),
  .chk_zero_o  (chk_zero_o),
  .rem_o       (rem_o)
);

// File: tb/tb_crc_serial.sv
module tb_crc_serial;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic mode_chk = 1'b0;
  logic v16 = 1'b0, v5 = 1'b0;
  logic in_bit = 1'b0, in_last = 1'b0, out_ready = 1'b0;

  logic rdy16, ov16, ob16, ol16, cd16, cz16;
  logic [15:0] rem16;
  logic rdy5, ov5, ob5, ol5, cd5, cz5;
  logic [4:0] rem5;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  crc_serial #(.W(16), .POLY(16'h8005)) dut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .mode_chk_i(mode_chk),
    .in_valid_i(v16), .in_ready_o(rdy16), .in_bit_i(in_bit), .in_last_i(in_last),
    .out_valid_o(ov16), .out_ready_i(out_ready), .out_bit_o(ob16), .out_last_o(ol16),
    .chk_done_o(cd16), .chk_zero_o(cz16), .rem_o(rem16));

  crc_serial #(.W(5), .POLY(5'h05)) dut_tok (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .mode_chk_i(mode_chk),
    .in_valid_i(v5), .in_ready_o(rdy5), .in_bit_i(in_bit), .in_last_i(in_last),
    .out_valid_o(ov5), .out_ready_i(out_ready), .out_bit_o(ob5), .out_last_o(ol5),
    .chk_done_o(cd5), .chk_zero_o(cz5), .rem_o(rem5));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_rem(input logic [63:0] msg, input int len,
                                          input int n, input logic [16:0] g);
    logic [79:0] v;
    v = {16'b0, msg} << n;
    for (int i = len + n - 1; i >= n; i--)
      if (v[i]) for (int j = 0; j <= n; j++) v[i-n+j] ^= g[j];
    return v[15:0] & 16'((32'd1 << n) - 1);
  endfunction

  // starts and ends at a negedge; ends on the negedge right after the last handshake
  task automatic feed(input bit tok, input logic [63:0] msg, input int len,
                      input bit gaps, input bit ends);
    for (int i = len - 1; i >= 0; i--) begin
      if (gaps) begin
        v16 = 1'b0; v5 = 1'b0; in_bit = ~msg[i];
        @(negedge clk);
      end
      in_bit = msg[i];
      in_last = ends && (i == 0);
      if (tok) v5 = 1'b1; else v16 = 1'b1;
      while (!(tok ? rdy5 : rdy16)) @(negedge clk);
      @(negedge clk);
    end
    v16 = 1'b0; v5 = 1'b0; in_last = 1'b0;
  endtask

  // collects n remainder beats, optionally stalling before beat 1
  task automatic drain(input bit tok, input int n, input bit stall, output logic [15:0] bits);
    bits = '0;
    for (int k = 0; k < n; k++) begin
      if (stall && k == 1) begin
        logic b0;
        out_ready = 1'b0;
        b0 = tok ? ob5 : ob16;
        @(negedge clk);
        @(negedge clk);
        chk((tok ? ov5 : ov16) && ((tok ? ob5 : ob16) == b0), "R5", "stall hold",
            tok ? ob5 : ob16, b0);
      end
      out_ready = 1'b1;
      chk((tok ? ov5 : ov16) === 1'b1, "R4", "flush valid", tok ? ov5 : ov16, 1);
      chk((tok ? ol5 : ol16) === (k == n - 1), "R4", "last beat", tok ? ol5 : ol16, k == n - 1);
      bits = {bits[14:0], (tok ? ob5 : ob16)};
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk((tok ? ov5 : ov16) === 1'b0, "R4", "flush length", tok ? ov5 : ov16, 0);
  endtask

  task automatic t_reset;
    chk(rdy16 && !ov16 && !cd16 && !ol16 && rem16 == 0, "R1", "reset state 16",
        {rdy16, ov16, cd16, rem16}, {1'b1, 2'b0, 16'h0});
    chk(rdy5 && !ov5 && !cd5 && rem5 == 0, "R1", "reset state 5", {rdy5, ov5, cd5, rem5}, 8'h80);
  endtask

  task automatic t_gen16(input logic [63:0] msg, input int len, input bit gaps, input bit stall);
    logic [15:0] exp, bits;
    exp = ref_rem(msg, len, 16, 17'h18005);
    mode_chk = 1'b0;
    feed(1'b0, msg, len, gaps, 1'b1);
    chk(rem16 == exp, gaps ? "R10" : "R2", "gen remainder", rem16, exp);
    chk(!rdy16, "R4", "ready low in flush", rdy16, 0);
    drain(1'b0, 16, stall, bits);
    chk(bits == exp, "R4", "serial remainder", bits, exp);
    chk(rdy16 && rem16 == 0, "R6", "back to idle", {rdy16, rem16}, {1'b1, 16'h0});
  endtask

  task automatic t_token;
    logic [15:0] bits;
    mode_chk = 1'b0;
    feed(1'b1, 64'hA5, 8, 1'b0, 1'b1);
    chk(rem5 == 5'b01110, "R3", "token remainder", rem5, 5'b01110);
    // junk on the input during flush must be ignored
    v5 = 1'b1; in_bit = 1'b1; in_last = 1'b1;
    @(negedge clk);
    chk(!rdy5 && rem5 == 5'b01110, "R4", "input ignored in flush", rem5, 5'b01110);
    v5 = 1'b0; in_last = 1'b0;
    drain(1'b1, 5, 1'b0, bits);
    chk(bits[4:0] == 5'b01110, "R3", "token serial bits", bits[4:0], 5'b01110);
    mode_chk = 1'b1;
    feed(1'b1, 64'b1010010101110, 13, 1'b0, 1'b1);
    chk(cd5 && cz5 && !rdy5, "R3", "token codeword clean", {cd5, cz5, rdy5}, 3'b110);
    @(negedge clk);
    chk(!cd5 && rdy5 && rem5 == 0, "R7", "verdict one cycle", {cd5, rdy5}, 2'b01);
    mode_chk = 1'b0;
  endtask

  task automatic t_check16(input logic [63:0] msg, input int len, input logic [63:0] flip);
    logic [63:0] cw;
    bit clean;
    cw = ((msg << 16) | 64'(ref_rem(msg, len, 16, 17'h18005))) ^ flip;
    clean = (flip == 0);
    mode_chk = 1'b1;
    feed(1'b0, cw, len + 16, 1'b0, 1'b1);
    chk(cd16 === 1'b1 && !rdy16, "R7", "verdict strobe", {cd16, rdy16}, 2'b10);
    chk(cz16 === clean, clean ? "R7" : "R8", "zero flag", cz16, clean);
    @(negedge clk);
    chk(!cd16 && rdy16, "R7", "strobe drops", {cd16, rdy16}, 2'b01);
    mode_chk = 1'b0;
  endtask

  task automatic t_mode_latch;
    logic [15:0] exp, bits;
    exp = ref_rem(64'hC3A, 12, 16, 17'h18005);
    mode_chk = 1'b0;
    feed(1'b0, 64'hC3A >> 6, 6, 1'b0, 1'b0);
    mode_chk = 1'b1;
    feed(1'b0, 64'hC3A & 64'h3F, 6, 1'b0, 1'b1);
    chk(ov16 && !cd16, "R9", "mode held as generate", {ov16, cd16}, 2'b10);
    drain(1'b0, 16, 1'b0, bits);
    chk(bits == exp, "R9", "remainder after mode flip", bits, exp);
    mode_chk = 1'b0;
  endtask

  task automatic t_clear;
    feed(1'b0, 64'hBEEF, 16, 1'b0, 1'b0);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk(rem16 == 0 && rdy16, "R1", "clear mid message", rem16, 0);
    feed(1'b0, 64'h5A, 8, 1'b0, 1'b1);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk(!ov16 && rdy16 && rem16 == 0, "R1", "clear mid flush", {ov16, rdy16}, 2'b01);
    t_gen16(64'h1234, 16, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gen16(64'h1234, 16, 1'b0, 1'b0);
    t_gen16(64'hA5, 8, 1'b1, 1'b0);
    t_gen16(64'hFFFF_0001, 32, 1'b0, 1'b1);
    t_gen16(64'h1, 1, 1'b0, 1'b0);
    t_token();
    t_check16(64'hDEAD, 16, 64'h0);
    t_check16(64'hDEAD, 16, 64'h1 << 20);
    t_check16(64'h7, 3, 64'h0);
    t_check16(64'hCAFE_F00D, 32, (64'h1 << 3) | (64'h1 << 40));
    t_mode_latch();
    t_clear();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule